// File: doc/BRIEF.md
# Capture Ring Buffer

This block collects a continuous stream of 4-bit I/Q sample nibbles into a 2048-bit on-chip memory that works as a circular buffer. Each valid sample strobe writes one nibble at the current write pointer. The pointer then moves on by one entry and wraps back to the start when it reaches the end of the memory. Nothing stops the writer, so the oldest data is overwritten without notice.

A host processor reads the buffer through an asynchronous, SRAM-like memory interface. It uses an active-low chip select, an active-low output enable and an active-low write enable. The host sees the buffer as ordinary memory. Each 8-bit word holds two consecutive samples. A small status window returns the write pointer and a sticky wrap flag, so that software can find where fresh data begins.

The write pointer is Gray-coded and passed through a two-flop synchronizer into the host clock domain. The memory has read-first semantics: a host read that hits the entry being written in the same cycle returns the old contents. The bus itself is tristated outside the block. The block provides the read data and a drive-enable for the pad.

Top module: `capture_ring`

## Requirements
- R1: After reset the write pointer is 0 and the wrap flag is clear. Both status bytes read as 8'h00 before any sample arrives.
- R2: Each cycle with `smp_valid` high writes `smp_nib` into the entry at the write pointer and advances the pointer by one. With `smp_valid` low, the pointer holds.
- R3: A host read at address a, with bit 8 clear, returns entry 2a in bits 3:0 and entry 2a+1 in bits 7:4. The data is valid from the first host clock edge after the address, chip select and output enable are applied.
- R4: The write pointer wraps from 511 to 0. The 513th sample after reset overwrites entry 0.
- R5: When a sample write and a host read hit the same word at the same clock edge, the read returns the contents from before the write. The read at the next edge returns the new contents.
- R6: `host_rdata_en` is high only while both `host_cs_n` and `host_oe_n` are low. While it is low, `host_rdata` is 8'h00.
- R7: A read with address bit 8 set and bit 0 clear returns pointer bits 7:0. With bit 8 set and bit 0 set, it returns the wrap flag in bit 7, pointer bit 8 in bit 0 and zeros elsewhere. The pointer value is the synchronized one and settles within four host clocks after the last sample.
- R8: The wrap flag sets when the synchronized pointer wraps. It then stays set through further samples.
- R9: A host write (`host_cs_n` and `host_we_n` low) to an address with bit 8 set and bit 0 clear clears the wrap flag. A host write to a data address leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample-domain clock |
| rst_smp | input | 1 | Synchronous active-high reset, sample domain |
| smp_valid | input | 1 | Sample strobe: write `smp_nib` this cycle |
| smp_nib | input | 4 | Sample nibble to store |
| clk_host | input | 1 | Host-domain clock |
| rst_host | input | 1 | Synchronous active-high reset, host domain |
| host_addr | input | 9 | Host address; bit 8 selects the status window |
| host_cs_n | input | 1 | Active-low chip select |
| host_oe_n | input | 1 | Active-low output enable |
| host_we_n | input | 1 | Active-low write enable (control writes only) |
| host_rdata | output | 8 | Read data toward the bus pad |
| host_rdata_en | output | 1 | Pad drive enable; the pad floats when low |

## Verification
The bench builds the block with its default parameters: 4-bit samples, 512 entries and an 8-bit host word. At these sizes a full pointer wrap costs only a few hundred strobes, so both the first and the second wrap are within reach. The bench drives both clock inputs from one clock. This places a sample write and a host read at the very same edge, which makes the read-first collision observable at the ports. It also gives the Gray synchronizer a fixed, known latency for the status reads.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int unsigned CODE_W = 16;

    typedef enum logic [1:0] {
        HSEL_IDLE = 2'd0,
        HSEL_WORD = 2'd1,
        HSEL_STLO = 2'd2,
        HSEL_STHI = 2'd3
    } hsel_e;

    typedef struct packed {
        hsel_e sel;
        logic  ctrl_wr;
    } host_dec_t;

    function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
        logic [CODE_W-1:0] b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/cap_wr_ctrl.sv
module cap_wr_ctrl
    import cap_pkg::*;
#(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_gray
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;
    logic [PTR_W-1:0] gray_q;

    always_comb begin
        ptr_d = ptr_q;
        if (valid) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            gray_q <= '0;
        end else begin
            ptr_q  <= ptr_d;
            gray_q <= PTR_W'(bin2gray(CODE_W'(ptr_d)));
        end
    end

    assign ptr      = ptr_q;
    assign ptr_gray = gray_q;

endmodule

// File: rtl/cap_ring_mem.sv
module cap_ring_mem #(
    parameter int unsigned SMP_W   = 4,
    parameter int unsigned LANES   = 2,
    parameter int unsigned WORDS   = 256,
    parameter int unsigned PTR_W   = 9,
    parameter int unsigned WADDR_W = $clog2(WORDS)
) (
    input  logic                   wclk,
    input  logic                   we,
    input  logic [PTR_W-1:0]       wentry,
    input  logic [SMP_W-1:0]       wdata,
    input  logic                   rclk,
    input  logic [WADDR_W-1:0]     raddr,
    output logic [SMP_W*LANES-1:0] rdata
);
    localparam int unsigned LANE_BITS = $clog2(LANES);

    logic [WADDR_W-1:0]   wword;
    logic [LANE_BITS-1:0] wlane;

    assign wword = wentry[PTR_W-1:LANE_BITS];
    assign wlane = wentry[LANE_BITS-1:0];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SMP_W-1:0] bank [WORDS];
        logic [SMP_W-1:0] rd_q;

        always_ff @(posedge wclk) begin
            if (we && (wlane == LANE_BITS'(l))) begin
                bank[wword] <= wdata;
            end
        end

        // Read-first: the nonblocking read sees the value before any write this edge
        always_ff @(posedge rclk) begin
            rd_q <= bank[raddr];
        end

        assign rdata[l*SMP_W +: SMP_W] = rd_q;
    end

endmodule

// File: rtl/cap_ptr_sync.sv
module cap_ptr_sync
    import cap_pkg::*;
#(
    parameter int unsigned PTR_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] ptr_bin,
    output logic             wrap_evt
);
    logic [PTR_W-1:0] meta_q;
    logic [PTR_W-1:0] sync_q;
    logic [PTR_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
            prev_q <= ptr_bin;
        end
    end

    assign ptr_bin  = PTR_W'(gray2bin(CODE_W'(sync_q)));
    // The pointer only moves forward; a smaller value means it passed the end
    assign wrap_evt = (ptr_bin < prev_q);

endmodule

// File: rtl/cap_host_port.sv
module cap_host_port
    import cap_pkg::*;
#(
    parameter int unsigned HOST_W  = 8,
    parameter int unsigned PTR_W   = 9,
    parameter int unsigned WADDR_W = 8,
    parameter int unsigned HADDR_W = WADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HADDR_W-1:0] addr,
    input  logic               cs_n,
    input  logic               oe_n,
    input  logic               we_n,
    input  logic [HOST_W-1:0]  mem_rdata,
    input  logic [PTR_W-1:0]   ptr_bin,
    input  logic               wrap_evt,
    output logic [WADDR_W-1:0] mem_raddr,
    output logic [HOST_W-1:0]  rdata,
    output logic               rdata_en,
    output logic               wrap_flag,
    output logic               wrap_clr
);
    host_dec_t        dec;
    hsel_e            sel_q;
    logic             ctrl_q;
    logic             flag_q;
    logic [HOST_W-1:0] stat_lo;
    logic [HOST_W-1:0] stat_hi;
    logic [HOST_W-1:0] mux;

    always_comb begin
        dec.sel     = HSEL_IDLE;
        dec.ctrl_wr = 1'b0;
        if (!cs_n && !oe_n) begin
            if (!addr[HADDR_W-1])  dec.sel = HSEL_WORD;
            else if (addr[0])      dec.sel = HSEL_STHI;
            else                   dec.sel = HSEL_STLO;
        end
        if (!cs_n && !we_n && addr[HADDR_W-1] && !addr[0]) begin
            dec.ctrl_wr = 1'b1;
        end
    end

    assign mem_raddr = addr[WADDR_W-1:0];
    assign wrap_clr  = dec.ctrl_wr && !ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= HSEL_IDLE;
            ctrl_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            sel_q  <= dec.sel;
            ctrl_q <= dec.ctrl_wr;
            if (wrap_evt)      flag_q <= 1'b1;
            else if (wrap_clr) flag_q <= 1'b0;
        end
    end

    assign wrap_flag = flag_q;

    always_comb begin
        stat_lo = '0;
        stat_hi = '0;
        for (int i = 0; i < int'(HOST_W); i++) begin
            if (i < int'(PTR_W))          stat_lo[i] = ptr_bin[i];
            if (i + HOST_W < PTR_W)       stat_hi[i] = ptr_bin[i+HOST_W];
        end
        stat_hi[HOST_W-1] = flag_q;
    end

    always_comb begin
        case (sel_q)
            HSEL_WORD: mux = mem_rdata;
            HSEL_STLO: mux = stat_lo;
            HSEL_STHI: mux = stat_hi;
            default:   mux = '0;
        endcase
    end

    assign rdata_en = !cs_n && !oe_n;
    assign rdata    = rdata_en ? mux : '0;

endmodule

// File: rtl/capture_ring.sv
module capture_ring
    import cap_pkg::*;
#(
    parameter int unsigned SMP_W  = 4,
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned HOST_W = 8
) (
    input  logic                         clk_smp,
    input  logic                         rst_smp,
    input  logic                         smp_valid,
    input  logic [SMP_W-1:0]             smp_nib,
    input  logic                         clk_host,
    input  logic                         rst_host,
    input  logic [$clog2(DEPTH*SMP_W/HOST_W):0] host_addr,
    input  logic                         host_cs_n,
    input  logic                         host_oe_n,
    input  logic                         host_we_n,
    output logic [HOST_W-1:0]            host_rdata,
    output logic                         host_rdata_en
);
    localparam int unsigned LANES   = HOST_W / SMP_W;
    localparam int unsigned WORDS   = DEPTH / LANES;
    localparam int unsigned PTR_W   = $clog2(DEPTH);
    localparam int unsigned WADDR_W = $clog2(WORDS);
    localparam int unsigned HADDR_W = WADDR_W + 1;

    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   ptr_gray;
    logic [PTR_W-1:0]   sync_ptr;
    logic               wrap_evt;
    logic               wrap_flag;
    logic               wrap_clr;
    logic [WADDR_W-1:0] mem_raddr;
    logic [HOST_W-1:0]  mem_rdata;

    cap_wr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr (
        .clk      (clk_smp),
        .rst      (rst_smp),
        .valid    (smp_valid),
        .ptr      (wr_ptr),
        .ptr_gray (ptr_gray)
    );

    cap_ring_mem #(
        .SMP_W(SMP_W), .LANES(LANES), .WORDS(WORDS),
        .PTR_W(PTR_W), .WADDR_W(WADDR_W)
    ) u_mem (
        .wclk   (clk_smp),
        .we     (smp_valid),
        .wentry (wr_ptr),
        .wdata  (smp_nib),
        .rclk   (clk_host),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    cap_ptr_sync #(.PTR_W(PTR_W)) u_sync (
        .clk      (clk_host),
        .rst      (rst_host),
        .gray_in  (ptr_gray),
        .ptr_bin  (sync_ptr),
        .wrap_evt (wrap_evt)
    );

    cap_host_port #(
        .HOST_W(HOST_W), .PTR_W(PTR_W), .WADDR_W(WADDR_W), .HADDR_W(HADDR_W)
    ) u_host (
        .clk       (clk_host),
        .rst       (rst_host),
        .addr      (host_addr),
        .cs_n      (host_cs_n),
        .oe_n      (host_oe_n),
        .we_n      (host_we_n),
        .mem_rdata (mem_rdata),
        .ptr_bin   (sync_ptr),
        .wrap_evt  (wrap_evt),
        .mem_raddr (mem_raddr),
        .rdata     (host_rdata),
        .rdata_en  (host_rdata_en),
        .wrap_flag (wrap_flag),
        .wrap_clr  (wrap_clr)
    );

endmodule

// File: rtl/cap_ring_chk.sv
module cap_ring_chk #(
    parameter int unsigned DEPTH  = 512,
    parameter int unsigned PTR_W  = 9,
    parameter int unsigned HOST_W = 8
) (
    input logic              clk_smp,
    input logic              rst_smp,
    input logic              smp_valid,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [PTR_W-1:0]  ptr_gray,
    input logic              clk_host,
    input logic              rst_host,
    input logic              host_cs_n,
    input logic              host_oe_n,
    input logic [HOST_W-1:0] host_rdata,
    input logic              host_rdata_en,
    input logic              wrap_flag,
    input logic              wrap_evt,
    input logic              wrap_clr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    p_ptr_adv_r2: assert property (@(posedge clk_smp) disable iff (rst_smp)
        (smp_valid && wr_ptr != LAST) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    p_ptr_hold_r2: assert property (@(posedge clk_smp) disable iff (rst_smp)
        !smp_valid |=> $stable(wr_ptr));

    p_ptr_wrap_r4: assert property (@(posedge clk_smp) disable iff (rst_smp)
        (smp_valid && wr_ptr == LAST) |=> (wr_ptr == '0));

    p_gray_step_r7: assert property (@(posedge clk_smp) disable iff (rst_smp)
        $countones(ptr_gray ^ $past(ptr_gray)) <= 1);

    p_bus_off_r6: assert property (@(posedge clk_host) disable iff (rst_host)
        (host_cs_n || host_oe_n) |-> !host_rdata_en);

    p_bus_quiet_r6: assert property (@(posedge clk_host) disable iff (rst_host)
        !host_rdata_en |-> (host_rdata == '0));

    p_wrap_set_r8: assert property (@(posedge clk_host) disable iff (rst_host)
        wrap_evt |=> wrap_flag);

    p_wrap_sticky_r8: assert property (@(posedge clk_host) disable iff (rst_host)
        (wrap_flag && !wrap_clr) |=> wrap_flag);

    p_wrap_clear_r9: assert property (@(posedge clk_host) disable iff (rst_host)
        (wrap_clr && !wrap_evt) |=> !wrap_flag);

endmodule

bind capture_ring cap_ring_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .HOST_W(HOST_W)) u_chk (
    .clk_smp       (clk_smp),
    .rst_smp       (rst_smp),
    .smp_valid     (smp_valid),
    .wr_ptr        (wr_ptr),
    .ptr_gray      (ptr_gray),
    .clk_host      (clk_host),
    .rst_host      (rst_host),
    .host_cs_n     (host_cs_n),
    .host_oe_n     (host_oe_n),
    .host_rdata    (host_rdata),
    .host_rdata_en (host_rdata_en),
    .wrap_flag     (wrap_flag),
    .wrap_evt      (wrap_evt),
    .wrap_clr      (wrap_clr)
);

// File: tb/capture_ring_bench.sv
module capture_ring_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_valid = 1'b0;
    logic [3:0] smp_nib = '0;
    logic [8:0] host_addr = '0;
    logic       cs_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [7:0] rdata;
    logic       rdata_en;

    always #5 clk = ~clk;

    capture_ring u_capture_ring (
        .clk_smp       (clk),
        .rst_smp       (rst),
        .smp_valid     (smp_valid),
        .smp_nib       (smp_nib),
        .clk_host      (clk),
        .rst_host      (rst),
        .host_addr     (host_addr),
        .host_cs_n     (cs_n),
        .host_oe_n     (oe_n),
        .host_we_n     (we_n),
        .host_rdata    (rdata),
        .host_rdata_en (rdata_en)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    logic [3:0] exp_mem [512];
    int         m_ptr  = 0;
    bit         m_wrap = 1'b0;
    int         pat    = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    int         issued = 0;
    int         popped = 0;

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Monitor: compares each queued expectation one edge after the read was set up
    always @(posedge clk) begin
        #1;
        if (issued > popped) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            popped++;
            chk({t, " enable"}, {7'd0, rdata_en}, 8'd1);
            chk(t, rdata, e);
        end
    end

    task automatic expect_rd(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        issued++;
    endtask

    function automatic logic [7:0] word_of(input int a);
        return {exp_mem[2*a+1], exp_mem[2*a]};
    endfunction

    function automatic logic [7:0] stat_hi();
        return {m_wrap, 6'd0, 1'(m_ptr >> 8)};
    endfunction

    task automatic send_samples(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_nib   = 4'((pat * 7 + 3) & 15);
            exp_mem[m_ptr] = smp_nib;
            pat++;
            m_ptr = (m_ptr + 1) % 512;
            if (m_ptr == 0) m_wrap = 1'b1;
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic host_read(input logic [8:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        host_addr = a;
        cs_n = 1'b0;
        oe_n = 1'b0;
        expect_rd(e, t);
        @(negedge clk);
        cs_n = 1'b1;
        oe_n = 1'b1;
    endtask

    task automatic host_write(input logic [8:0] a);
        @(negedge clk);
        host_addr = a;
        cs_n = 1'b0;
        we_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1;
        we_n = 1'b1;
        if (a[8] && !a[0]) m_wrap = 1'b0;
    endtask

    task automatic idle_check(input logic c, input logic o);
        @(negedge clk);
        cs_n = c;
        oe_n = o;
        #1;
        chk("R6 enable idle", {7'd0, rdata_en}, 8'd0);
        chk("R6 data idle", rdata, 8'd0);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic read_status(input string t);
        host_read(9'h100, 8'(m_ptr), {t, " ptr low"});
        host_read(9'h101, stat_hi(), {t, " status high"});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R7 status layout
        read_status("R1 R7");

        // R6 drive enable only with both strobes low
        idle_check(1'b1, 1'b1);
        idle_check(1'b0, 1'b1);
        idle_check(1'b1, 1'b0);
        cs_n = 1'b1;
        oe_n = 1'b1;

        // R2 R3 nibble packing and pointer advance
        send_samples(10);
        for (int a = 0; a < 5; a++) host_read(9'(a), word_of(a), "R3 word read");
        settle();
        read_status("R2 R7");

        // R2 no strobe: pointer holds
        repeat (8) @(negedge clk);
        read_status("R2 hold");

        // fill to 511 samples: no wrap yet
        send_samples(501);
        settle();
        read_status("R8 before wrap");

        // 512th sample: pointer returns to 0, flag sets
        send_samples(1);
        settle();
        read_status("R4 R8 wrap");

        // 513th sample overwrites entry 0
        send_samples(1);
        host_read(9'h000, word_of(0), "R4 overwrite");

        // R5 read-first collision on word 0, entry 1
        @(negedge clk);
        smp_valid = 1'b1;
        smp_nib   = 4'hA ^ exp_mem[1];
        host_addr = 9'h000;
        cs_n = 1'b0;
        oe_n = 1'b0;
        expect_rd(word_of(0), "R5 old data");
        exp_mem[m_ptr] = smp_nib;
        m_ptr = (m_ptr + 1) % 512;
        @(negedge clk);
        smp_valid = 1'b0;
        expect_rd(word_of(0), "R5 new data");
        @(negedge clk);
        cs_n = 1'b1;
        oe_n = 1'b1;

        // R8 flag sticky across more samples
        send_samples(20);
        settle();
        read_status("R8 sticky");

        // R9 data-address write leaves flag alone; control write clears it
        host_write(9'h005);
        settle();
        read_status("R9 data write");
        host_write(9'h100);
        settle();
        read_status("R9 cleared");
        send_samples(3);
        settle();
        read_status("R9 stays clear");

        // R8 second wrap sets it again
        send_samples(512);
        settle();
        read_status("R8 second wrap");
        for (int a = 250; a < 256; a++) host_read(9'(a), word_of(a), "R3 upper words");

        repeat (4) @(negedge clk);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule